// File: doc/BRIEF.md
# Power-Fail Store and Power-Up Recall Sequencer

This block decides when a volatile SRAM array and its nonvolatile shadow copy exchange their contents around supply events. Two digital flags replace the analog comparators: `vsw_ok` is high while the supply is above the switch threshold, and `vrst_low` is high while the supply is below the lower reset threshold. The block sends one-cycle launch pulses for a store or a recall to a separate transfer engine. It ends each transfer when the engine reports completion or when a cycle budget runs out. It drives a busy output and tells the SRAM controller when writes may proceed.

The block tracks whether the SRAM has been written since the last transfer. On a supply drop, a store happens only if there is unsaved data; otherwise busy shows a short fixed pulse and nothing is stored. A recall is armed only by a dip below the reset level, and also at power-up. It runs once the supply is back above the switch level. A mode pin, captured during reset, can turn off the automatic store. Stores requested by software or by the hardware request pin still work in that mode.

Top module: `nv_power_sequencer`

## Requirements
- R1: While and just after `rst` is high, `busy`, `wr_allow`, `store_go` and `recall_go` are all 0. The block waits in the powered-down phase with a recall already armed.
- R2: When `vsw_ok` is high and a recall is armed, `recall_go` is 1 for exactly one cycle, one clock later. `wr_allow` stays 0 while the recall runs.
- R3: A recall or a store ends in the clock after `xfer_done` is seen, or after RECALL_CYCLES (recall) or STORE_CYCLES (store) cycles, whichever comes first. If `vsw_ok` is high, `wr_allow` then returns to 1.
- R4: A pulse on `sram_wr_done` while `wr_allow` is 1 marks the array as unsaved. The end of any store or recall clears that mark.
- R5: In automatic mode, when `vsw_ok` falls and the array is unsaved, `store_go` and `busy` go to 1 one clock later. `busy` stays 1 until the store ends as in R3.
- R6: In automatic mode, when `vsw_ok` falls and the array is not unsaved, `busy` is 1 for exactly NOSTORE_CYCLES cycles and `store_go` stays 0.
- R7: A cycle with `vrst_low` high arms a recall, and recovery then gives `recall_go`. A drop of `vsw_ok` without `vrst_low` gives no recall on recovery, and `wr_allow` returns one clock after `vsw_ok` rises.
- R8: While `vsw_ok` is 0, `wr_allow` is 0. Writes, `sw_store_req` and `hw_store_req` have no effect: no launch, and the array is not marked unsaved.
- R9: `inhibit_mode` is sampled only while `rst` is high. When it was 1, a fall of `vsw_ok` gives no busy and no store, but a software store still launches.
- R10: With `vsw_ok` high and the block idle, `sw_store_req` launches a store whether or not the array is unsaved.
- R11: With `vsw_ok` high and the block idle, `hw_store_req` launches a store only when the array is unsaved; otherwise it is ignored.
- R12: If a store request arrives in the same cycle that `vsw_ok` returns with a recall armed, the recall wins. Only `recall_go` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures the mode |
| inhibit_mode | input | 1 | 1 = automatic store disabled (sampled during reset) |
| vsw_ok | input | 1 | Supply is above the switch threshold |
| vrst_low | input | 1 | Supply is below the reset threshold |
| sram_wr_done | input | 1 | One-cycle pulse per completed SRAM write |
| sw_store_req | input | 1 | Software store sequence recognised (pulse) |
| hw_store_req | input | 1 | Hardware store request pin, active high |
| xfer_done | input | 1 | Transfer engine finished the current operation |
| store_go | output | 1 | One-cycle store launch |
| recall_go | output | 1 | One-cycle recall launch |
| busy | output | 1 | Store in progress or no-store busy pulse |
| wr_allow | output | 1 | SRAM writes permitted |

## Verification
A wrong unsaved mark shows up at the next supply drop. A stale mark launches `store_go` where only the fixed busy pulse belongs, and a lost mark does the reverse. This is visible one clock after `vsw_ok` falls. A wrong recall arm shows one clock after `vsw_ok` rises, as a missing or extra `recall_go` with `wr_allow` held low. A cycle budget that is off by one moves the falling edge of `busy`, or the return of `wr_allow`, by exactly one clock. The bench therefore samples the cycle just before and just after each boundary.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

    typedef enum logic [2:0] {
        PH_DOWN    = 3'd0,
        PH_RECALL  = 3'd1,
        PH_IDLE    = 3'd2,
        PH_STORE   = 3'd3,
        PH_NOSTORE = 3'd4
    } phase_t;

    typedef struct packed {
        logic store;
        logic recall;
    } launch_t;

    function automatic logic phase_is_timed(phase_t p);
        return (p == PH_RECALL) || (p == PH_STORE) || (p == PH_NOSTORE);
    endfunction

    function automatic logic phase_is_xfer(phase_t p);
        return (p == PH_RECALL) || (p == PH_STORE);
    endfunction

    function automatic int unsigned max_of3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/nvseq_phase_timer.sv
module nvseq_phase_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          hit
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit = run && (cnt_q == limit);

    AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q <= limit)); // R3

endmodule

// File: rtl/nvseq_dirty_track.sv
module nvseq_dirty_track (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic dirty
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dirty <= 1'b0;
        end else if (clr_i) begin
            dirty <= 1'b0;
        end else if (set_i) begin
            dirty <= 1'b1;
        end
    end

    AST_DIRTY_CLEARS_ON_END: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !dirty); // R4

endmodule

// File: rtl/nvseq_recall_arm.sv
module nvseq_recall_arm (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic take_i,
    output logic pending
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b1;
        end else if (arm_i) begin
            pending <= 1'b1;
        end else if (take_i) begin
            pending <= 1'b0;
        end
    end

    AST_ARM_STICKS: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> pending); // R7

endmodule

// File: rtl/nv_power_sequencer.sv
module nv_power_sequencer
    import nvseq_pkg::*;
#(
    parameter int unsigned STORE_CYCLES   = 1000000,
    parameter int unsigned RECALL_CYCLES  = 55000,
    parameter int unsigned NOSTORE_CYCLES = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic inhibit_mode,
    input  logic vsw_ok,
    input  logic vrst_low,
    input  logic sram_wr_done,
    input  logic sw_store_req,
    input  logic hw_store_req,
    input  logic xfer_done,
    output logic store_go,
    output logic recall_go,
    output logic busy,
    output logic wr_allow
);
    localparam int unsigned MAX_CYC = max_of3(STORE_CYCLES, RECALL_CYCLES, NOSTORE_CYCLES);
    localparam int unsigned TW      = $clog2(MAX_CYC + 1);

    phase_t        phase_q, phase_d;
    launch_t       launch_q, launch_d;
    logic          inhibit_q;
    logic          dirty;
    logic          recall_pend;
    logic          tmr_hit;
    logic [TW-1:0] tmr_limit;
    logic          xfer_end;

    // Mode is captured while reset is held and frozen afterwards.
    always_ff @(posedge clk) begin
        if (rst) begin
            inhibit_q <= inhibit_mode;
        end
    end

    always_comb begin
        unique case (phase_q)
            PH_STORE:   tmr_limit = TW'(STORE_CYCLES - 1);
            PH_RECALL:  tmr_limit = TW'(RECALL_CYCLES - 1);
            PH_NOSTORE: tmr_limit = TW'(NOSTORE_CYCLES - 1);
            default:    tmr_limit = '0;
        endcase
    end

    nvseq_phase_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (phase_is_timed(phase_q)),
        .limit (tmr_limit),
        .hit   (tmr_hit)
    );

    assign xfer_end = phase_is_xfer(phase_q) && (xfer_done || tmr_hit);
    assign wr_allow = (phase_q == PH_IDLE) && vsw_ok;
    assign busy     = (phase_q == PH_STORE) || (phase_q == PH_NOSTORE);

    nvseq_dirty_track u_dirty (
        .clk   (clk),
        .rst   (rst),
        .set_i (sram_wr_done && wr_allow),
        .clr_i (xfer_end),
        .dirty (dirty)
    );

    nvseq_recall_arm u_arm (
        .clk     (clk),
        .rst     (rst),
        .arm_i   (vrst_low),
        .take_i  (launch_d.recall),
        .pending (recall_pend)
    );

    always_comb begin
        phase_d  = phase_q;
        launch_d = '0;
        unique case (phase_q)
            PH_DOWN: begin
                if (vsw_ok) begin
                    if (recall_pend) begin
                        phase_d         = PH_RECALL;
                        launch_d.recall = 1'b1;
                    end else begin
                        phase_d = PH_IDLE;
                    end
                end
            end
            PH_IDLE: begin
                if (!vsw_ok) begin
                    if (inhibit_q) begin
                        phase_d = PH_DOWN;
                    end else if (dirty) begin
                        phase_d        = PH_STORE;
                        launch_d.store = 1'b1;
                    end else begin
                        phase_d = PH_NOSTORE;
                    end
                end else if (sw_store_req || (hw_store_req && dirty)) begin
                    phase_d        = PH_STORE;
                    launch_d.store = 1'b1;
                end
            end
            PH_STORE, PH_RECALL: begin
                if (xfer_end) begin
                    phase_d = vsw_ok ? PH_IDLE : PH_DOWN;
                end
            end
            PH_NOSTORE: begin
                if (tmr_hit) begin
                    phase_d = PH_DOWN;
                end
            end
            default: phase_d = PH_DOWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_DOWN;
            launch_q <= '0;
        end else begin
            phase_q  <= phase_d;
            launch_q <= launch_d;
        end
    end

    assign store_go  = launch_q.store;
    assign recall_go = launch_q.recall;

    AST_STORE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        store_go |-> ($past(dirty) || $past(sw_store_req))); // R5
    AST_ONE_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0({store_go, recall_go})); // R12
    AST_RECALL_WAS_ARMED: assert property (@(posedge clk) disable iff (rst)
        recall_go |-> $past(recall_pend)); // R7
    AST_NO_MARK_BELOW_SW: assert property (@(posedge clk) disable iff (rst)
        !vsw_ok |=> !$rose(dirty)); // R8
    AST_INHIBIT_NO_AUTO: assert property (@(posedge clk) disable iff (rst)
        (inhibit_q && (phase_q == PH_IDLE) && !vsw_ok) |=> !busy); // R9
    AST_BUSY_BLOCKS_WR: assert property (@(posedge clk) disable iff (rst)
        busy |-> !wr_allow); // R5

endmodule

// File: tb/nv_power_sequencer_tb_top.sv
module nv_power_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int S_CYC = 40;
    localparam int R_CYC = 24;
    localparam int N_CYC = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic inhibit_mode = 1'b0;
    logic vsw_ok = 1'b0;
    logic vrst_low = 1'b0;
    logic sram_wr_done = 1'b0;
    logic sw_store_req = 1'b0;
    logic hw_store_req = 1'b0;
    logic xfer_done = 1'b0;
    logic store_go, recall_go, busy, wr_allow;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nv_power_sequencer #(
        .STORE_CYCLES(S_CYC), .RECALL_CYCLES(R_CYC), .NOSTORE_CYCLES(N_CYC)
    ) dut_i (
        .clk(clk), .rst(rst), .inhibit_mode(inhibit_mode), .vsw_ok(vsw_ok),
        .vrst_low(vrst_low), .sram_wr_done(sram_wr_done), .sw_store_req(sw_store_req),
        .hw_store_req(hw_store_req), .xfer_done(xfer_done), .store_go(store_go),
        .recall_go(recall_go), .busy(busy), .wr_allow(wr_allow)
    );

    // Row layout: vsw vrst wr sw hw done | exp wr_allow busy store_go recall_go
    localparam int NV = 7;
    localparam logic [9:0] VEC [NV] = '{
        10'b1_0_0_0_0_0_1_0_0_0,
        10'b1_0_0_0_1_0_1_0_0_0,
        10'b1_0_1_0_0_0_1_0_0_0,
        10'b1_0_0_0_1_0_0_1_1_0,
        10'b1_0_0_0_0_1_1_0_0_0,
        10'b1_0_0_1_0_0_0_1_1_0,
        10'b1_0_0_0_0_1_1_0_0_0
    };
    localparam string VTAG [NV] = '{"R11", "R11", "R4", "R11", "R4", "R10", "R10"};

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) tick();
        chk("R1", "busy", busy, 0);
        chk("R1", "wr_allow", wr_allow, 0);
        chk("R1", "store_go", store_go, 0);
        chk("R1", "recall_go", recall_go, 0);
        rst = 1'b0;
        tick();
        chk("R1", "wr_allow after reset", wr_allow, 0);

        // R2/R3: power-up recall, ended by the cycle budget
        vsw_ok = 1'b1;
        tick();
        chk("R2", "recall_go", recall_go, 1);
        chk("R2", "wr_allow in recall", wr_allow, 0);
        for (int k = 1; k <= R_CYC; k++) begin
            tick();
            if (k == 1)         chk("R2", "recall_go single", recall_go, 0);
            if (k == R_CYC - 1) chk("R3", "wr_allow before budget", wr_allow, 0);
            if (k == R_CYC)     chk("R3", "wr_allow after budget", wr_allow, 1);
        end

        // Table walk: request handling while powered
        for (int i = 0; i < NV; i++) begin
            vsw_ok       = VEC[i][9];
            vrst_low     = VEC[i][8];
            sram_wr_done = VEC[i][7];
            sw_store_req = VEC[i][6];
            hw_store_req = VEC[i][5];
            xfer_done    = VEC[i][4];
            tick();
            chk(VTAG[i], "wr_allow", wr_allow, int'(VEC[i][3]));
            chk(VTAG[i], "busy", busy, int'(VEC[i][2]));
            chk(VTAG[i], "store_go", store_go, int'(VEC[i][1]));
            chk(VTAG[i], "recall_go", recall_go, int'(VEC[i][0]));
        end
        sram_wr_done = 1'b0; sw_store_req = 1'b0; hw_store_req = 1'b0; xfer_done = 1'b0;

        // R6/R8: drop with nothing unsaved, software request on the same cycle ignored
        vsw_ok = 1'b0;
        sw_store_req = 1'b1;
        tick();
        sw_store_req = 1'b0;
        chk("R6", "busy pulse start", busy, 1);
        chk("R8", "store_go on drop", store_go, 0);
        chk("R8", "wr_allow low", wr_allow, 0);
        for (int k = 1; k <= N_CYC; k++) begin
            tick();
            if (k == N_CYC - 1) chk("R6", "busy pulse last", busy, 1);
            if (k == N_CYC)     chk("R6", "busy pulse end", busy, 0);
            chk("R6", "no store in pulse", store_go, 0);
        end

        // R8: requests and writes while below switch have no effect
        sw_store_req = 1'b1; hw_store_req = 1'b1; sram_wr_done = 1'b1;
        tick();
        sw_store_req = 1'b0; hw_store_req = 1'b0; sram_wr_done = 1'b0;
        chk("R8", "store_go while down", store_go, 0);
        chk("R8", "busy while down", busy, 0);
        tick();
        // R7: brown-out without reset dip gives no recall
        vsw_ok = 1'b1;
        tick();
        chk("R7", "no recall_go", recall_go, 0);
        chk("R7", "wr_allow back", wr_allow, 1);
        vsw_ok = 1'b0;
        tick();
        chk("R8", "write below switch not kept: busy", busy, 1);
        chk("R8", "write below switch not kept: store_go", store_go, 0);
        repeat (N_CYC) tick();
        vsw_ok = 1'b1;
        tick();
        chk("R7", "wr_allow after pulse", wr_allow, 1);

        // R5: automatic store ended by the cycle budget
        sram_wr_done = 1'b1;
        tick();
        sram_wr_done = 1'b0;
        vsw_ok = 1'b0;
        tick();
        chk("R5", "store_go", store_go, 1);
        chk("R5", "busy", busy, 1);
        for (int k = 1; k <= S_CYC; k++) begin
            tick();
            if (k == 1)         chk("R5", "store_go single", store_go, 0);
            if (k == S_CYC - 1) chk("R5", "busy before budget", busy, 1);
            if (k == S_CYC)     chk("R5", "busy after budget", busy, 0);
        end
        // R7: reset dip arms a recall
        vrst_low = 1'b1;
        tick();
        vrst_low = 1'b0;
        tick();
        vsw_ok = 1'b1;
        tick();
        chk("R7", "recall_go after dip", recall_go, 1);
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
        chk("R3", "wr_allow after done", wr_allow, 1);

        // R4: store completion clears the unsaved mark
        sram_wr_done = 1'b1;
        tick();
        sram_wr_done = 1'b0;
        sw_store_req = 1'b1;
        tick();
        sw_store_req = 1'b0;
        chk("R10", "store_go sw", store_go, 1);
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
        chk("R3", "wr_allow after store done", wr_allow, 1);
        vsw_ok = 1'b0;
        tick();
        chk("R4", "mark cleared: store_go", store_go, 0);
        chk("R4", "mark cleared: busy", busy, 1);
        repeat (N_CYC) tick();

        // R12: recall beats a simultaneous store request
        vrst_low = 1'b1;
        tick();
        vrst_low = 1'b0;
        vsw_ok = 1'b1;
        sw_store_req = 1'b1;
        tick();
        sw_store_req = 1'b0;
        chk("R12", "recall_go", recall_go, 1);
        chk("R12", "store_go", store_go, 0);
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;

        // R9: inhibit mode captured at reset only
        rst = 1'b1; inhibit_mode = 1'b1; vsw_ok = 1'b0;
        repeat (2) tick();
        rst = 1'b0; inhibit_mode = 1'b0;
        tick();
        vsw_ok = 1'b1;
        tick();
        chk("R9", "recall_go at power-up", recall_go, 1);
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
        sram_wr_done = 1'b1;
        tick();
        sram_wr_done = 1'b0;
        vsw_ok = 1'b0;
        tick();
        chk("R9", "busy on drop", busy, 0);
        chk("R9", "store_go on drop", store_go, 0);
        repeat (3) tick();
        chk("R9", "busy later", busy, 0);
        vsw_ok = 1'b1;
        tick();
        chk("R9", "wr_allow back", wr_allow, 1);
        chk("R9", "no recall", recall_go, 0);
        sw_store_req = 1'b1;
        tick();
        sw_store_req = 1'b0;
        chk("R9", "sw store in inhibit", store_go, 1);
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
        tick();

        summary();
        $finish;
    end

endmodule